// File: doc/BRIEF.md
# Serial Status Word Register

This block builds the 16-bit status word of a radio transceiver and returns it over a synchronous serial command port. The host lowers a chip select and then clocks command bits in on a data input, one per bit strobe, while the status word leaves on a data output, most significant bit first. A command whose first bit is 0 is a status read. Any command whose first bit is 1 is addressed to some other register, and the status flags ignore it.

Four event flags are sticky:
- a power-on reset event;
- a transmit underrun or receive overflow, with the source picked by the current mode;
- a wake-up timer overflow;
- a falling edge on the external interrupt pin, which is first passed through two synchronising flops.

Bit 15 shows transmit-ready in transmit mode and the receive FIFO threshold in receive mode. Bits 10:4 are seven live status levels and bits 3:0 are a two's-complement frequency offset. The whole word is copied into a shadow register when chip select falls. A completed status read clears only the flags it captured. An event that arrives during the read stays pending for the next read.

Top module: `stw_status_reg`

## Requirements
- R1: After reset every sticky flag is clear, so a read with all live inputs at 0 returns 0x0000. While cs_ni is high, sdo_o is 0.
- R2: The cycle after chip select falls, sdo_o presents word bit 15. Each bit strobe then moves to the next lower bit, so the word leaves MSB first.
- R3: A status read clears the sticky flags that were set at capture. A status read is 16 strobes in one chip-select frame with the first data bit 0.
- R4: A frame whose first data bit is 1 leaves every sticky flag unchanged.
- R5: Bit 15 is tx_rdy_i when tx_mode_i is 1 and fifo_thr_i when tx_mode_i is 0, sampled at capture.
- R6: Bit 13 is set by tx_unf_i in transmit mode and by rx_ovf_i in receive mode. The strobe belonging to the other mode has no effect.
- R7: por_evt_i sets bit 14 and wut_evt_i sets bit 12. Both bits stay set until a status read clears them.
- R8: Bit 11 is set only by a high-to-low change of ext_int_ni, three clock edges after the low level is first sampled. A steady low level or a rising edge does not set it.
- R9: Bits 10:4 come from live_i and bits 3:0 come from offset_i. Both are sampled at capture, so later changes during the frame do not alter the shifted word.
- R10: An event that arrives after capture survives the clear at the end of that read.
- R11: A frame that ends before 16 strobes clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select, synchronous to clk_i |
| bit_i | input | 1 | One-cycle strobe per serial bit |
| sdi_i | input | 1 | Serial command data in |
| sdo_o | output | 1 | Serial status data out |
| tx_mode_i | input | 1 | 1 = transmit mode, 0 = receive mode |
| tx_rdy_i | input | 1 | Transmit register can take a byte |
| fifo_thr_i | input | 1 | Receive FIFO fill reached threshold |
| tx_unf_i | input | 1 | Transmit underrun/overwrite strobe |
| rx_ovf_i | input | 1 | Receive FIFO overflow strobe |
| por_evt_i | input | 1 | Power-on reset event strobe |
| wut_evt_i | input | 1 | Wake-up timer overflow strobe |
| ext_int_ni | input | 1 | Asynchronous external interrupt pin |
| live_i | input | 7 | Live status levels for bits 10:4 |
| offset_i | input | 4 | Frequency offset, two's complement |

## Verification
A flag cleared by mistake, or one that stays stuck, is seen on the next full read. That read shows a bit that disagrees with the events the bench has sent since the last clearing read. A bad shift count or capture point shows within one strobe, as a bit placed one position off. A broken capture mask only shows one read later: an event sent during a frame is missing from the word of the next frame.

// File: rtl/stw_pkg.sv
package stw_pkg;
  localparam int WORD_W   = 16;
  localparam int CNT_W    = $clog2(WORD_W + 1);
  localparam int STICKY_N = 4;   // {por, unf/ovf, wut, ext} -> bits 14:11
  localparam int LIVE_W   = 7;
  localparam int OFF_W    = 4;
  localparam int SYNC_N   = 2;
endpackage

// File: rtl/stw_sync_fall.sv
module stw_sync_fall #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic fall_o
);
  // STAGES sync flops plus one history flop; idle level high
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-1:0], pin_ni};
  end

  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/stw_flag_bank.sv
module stw_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= (flag_q & ~(clr_i & clr_mask_i[g])) | set_i[g];
    end
    assign flag_o[g] = flag_q;
  end
endmodule

// File: rtl/stw_shifter.sv
module stw_shifter #(
  parameter int W     = 16,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_ni,
  input  logic         bit_i,
  input  logic         sdi_i,
  input  logic [W-1:0] word_i,
  output logic         cap_o,
  output logic         rd_done_o,
  output logic         sdo_o
);
  logic             cs_q;
  logic [W-1:0]     shadow_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cmd_q;
  logic             shift, first, cmd_bit;

  assign cap_o     = cs_q & ~cs_ni;
  assign shift     = ~cs_ni & ~cap_o & bit_i & (cnt_q < CNT_W'(W));
  assign first     = (cnt_q == '0);
  assign cmd_bit   = first ? sdi_i : cmd_q;
  assign rd_done_o = shift & (cnt_q == CNT_W'(W - 1)) & ~cmd_bit;
  assign sdo_o     = ~cs_ni & shadow_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q     <= 1'b1;
      shadow_q <= '0;
      cnt_q    <= '0;
      cmd_q    <= 1'b1;
    end else begin
      cs_q <= cs_ni;
      if (cs_ni) begin
        cnt_q <= '0;
      end else if (cap_o) begin
        shadow_q <= word_i;
        cnt_q    <= '0;
        cmd_q    <= 1'b1;
      end else if (shift) begin
        shadow_q <= {shadow_q[W-2:0], 1'b0};
        cnt_q    <= cnt_q + 1'b1;
        if (first) cmd_q <= sdi_i;
      end
    end
  end
endmodule

// File: rtl/stw_status_reg.sv
module stw_status_reg
  import stw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              bit_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic              tx_mode_i,
  input  logic              tx_rdy_i,
  input  logic              fifo_thr_i,
  input  logic              tx_unf_i,
  input  logic              rx_ovf_i,
  input  logic              por_evt_i,
  input  logic              wut_evt_i,
  input  logic              ext_int_ni,
  input  logic [LIVE_W-1:0] live_i,
  input  logic [OFF_W-1:0]  offset_i
);
  logic                ext_fall, cap, rd_done;
  logic [STICKY_N-1:0] sticky_set, sticky_q, cap_mask_q;
  logic [WORD_W-1:0]   word;

  stw_sync_fall #(.STAGES(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .pin_ni(ext_int_ni), .fall_o(ext_fall)
  );

  assign sticky_set = {por_evt_i, (tx_mode_i ? tx_unf_i : rx_ovf_i), wut_evt_i, ext_fall};

  // captured flags; a flag re-set during the frame is dropped from the mask
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cap_mask_q <= '0;
    else if (cap) cap_mask_q <= sticky_q;
    else          cap_mask_q <= cap_mask_q & ~sticky_set;
  end

  stw_flag_bank #(.N(STICKY_N)) u_flags (
    .clk_i, .rst_ni, .set_i(sticky_set), .clr_i(rd_done),
    .clr_mask_i(cap_mask_q), .flag_o(sticky_q)
  );

  assign word = {(tx_mode_i ? tx_rdy_i : fifo_thr_i), sticky_q, live_i, offset_i};

  stw_shifter #(.W(WORD_W)) u_shift (
    .clk_i, .rst_ni, .cs_ni, .bit_i, .sdi_i, .word_i(word),
    .cap_o(cap), .rd_done_o(rd_done), .sdo_o
  );
endmodule

// File: rtl/stw_status_reg_chk.sv
module stw_status_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       bit_i,
  input logic       sdo_o,
  input logic       tx_mode_i,
  input logic       tx_rdy_i,
  input logic       fifo_thr_i,
  input logic       ext_int_ni,
  input logic       cap,
  input logic       rd_done,
  input logic [3:0] sticky_q,
  input logic [3:0] cap_mask_q
);
  a_r1_sdo_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !sdo_o);

  a_r2_hold_between_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !$past(cs_ni) && !$past(cs_ni, 2) && !$past(bit_i)) |-> $stable(sdo_o));

  a_r5_bit15_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |=> (cs_ni || sdo_o == $past(tx_mode_i ? tx_rdy_i : fifo_thr_i)));

  a_r3_clear_only_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_done |=> (($past(sticky_q) & ~sticky_q) == 4'b0));

  a_r10_pending_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done |=> (($past(sticky_q) & ~$past(cap_mask_q) & ~sticky_q) == 4'b0));

  a_r8_ext_fall_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sticky_q[0]) |-> ($past(ext_int_ni, 3) == 1'b0 && $past(ext_int_ni, 4) == 1'b1));
endmodule

bind stw_status_reg stw_status_reg_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .bit_i(bit_i), .sdo_o(sdo_o),
  .tx_mode_i(tx_mode_i), .tx_rdy_i(tx_rdy_i), .fifo_thr_i(fifo_thr_i),
  .ext_int_ni(ext_int_ni), .cap(cap), .rd_done(rd_done),
  .sticky_q(sticky_q), .cap_mask_q(cap_mask_q)
);

// File: tb/stw_status_reg_bench.sv
module stw_status_reg_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, bit_i = 1'b0, sdi_i = 1'b0, sdo_o;
  logic tx_mode_i = 1'b0, tx_rdy_i = 1'b0, fifo_thr_i = 1'b0;
  logic tx_unf_i = 1'b0, rx_ovf_i = 1'b0, por_evt_i = 1'b0, wut_evt_i = 1'b0;
  logic ext_int_ni = 1'b1;
  logic [6:0] live_i = '0;
  logic [3:0] offset_i = '0;

  int checks = 0, errors = 0;
  logic [3:0] m_sticky = '0;   // {por, unf/ovf, wut, ext}

  always #5 clk_i = ~clk_i;

  stw_status_reg u_stw_status_reg (.*);

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic mode, input logic rdy, input logic thr,
                                           input logic [3:0] st, input logic [6:0] lv,
                                           input logic [3:0] off);
    return {(mode ? rdy : thr), st, lv, off};
  endfunction

  task automatic pulse(input logic por, input logic unf, input logic ovf, input logic wut);
    @(negedge clk_i);
    por_evt_i = por; tx_unf_i = unf; rx_ovf_i = ovf; wut_evt_i = wut;
    @(negedge clk_i);
    por_evt_i = 0; tx_unf_i = 0; rx_ovf_i = 0; wut_evt_i = 0;
    m_sticky |= {por, (tx_mode_i ? unf : ovf), wut, 1'b0};
  endtask

  task automatic ext_fall();
    @(negedge clk_i); ext_int_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    ext_int_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    m_sticky[0] = 1'b1;
  endtask

  // n strobes; inject a wut event mid-frame; perturb live inputs after capture
  task automatic do_read(input string tag, input logic [15:0] cmd, input int n, input bit inject);
    logic [15:0] exp, got, msk;
    logic [3:0] capm;
    @(negedge clk_i);
    cs_ni = 1'b0;
    exp  = exp_word(tx_mode_i, tx_rdy_i, fifo_thr_i, m_sticky, live_i, offset_i);
    capm = m_sticky;
    got  = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      got[15-i] = sdo_o;
      bit_i = 1'b1; sdi_i = cmd[15-i];
      wut_evt_i = (inject && i == 5);
      if (inject && i == 5) begin m_sticky[1] = 1'b1; capm[1] = 1'b0; end
      if (i == 3) begin
        live_i = 7'($urandom); offset_i = 4'($urandom);
        tx_rdy_i = ~tx_rdy_i; fifo_thr_i = ~fifo_thr_i;
      end
    end
    @(negedge clk_i);
    bit_i = 1'b0; wut_evt_i = 1'b0; cs_ni = 1'b1;
    msk = 16'hFFFF << (16 - n);
    check(tag, got & msk, exp & msk);
    if (n == 16 && !cmd[15]) m_sticky &= ~capm;
    @(negedge clk_i);
    check("R1 sdo idle", {15'b0, sdo_o}, 16'h0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    check("R1 sdo in reset", {15'b0, sdo_o}, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    do_read("R1 reset word", 16'h0000, 16, 0);
    // R7 sticky, R4 non-status frame keeps flags, R3 status read clears
    pulse(1, 0, 0, 1);
    do_read("R7 por/wut set", 16'h8123, 16, 0);
    do_read("R4 flags kept after cmd=1", 16'h8000, 16, 0);
    do_read("R3 read before clear", 16'h0000, 16, 0);
    do_read("R3 flags cleared", 16'h0000, 16, 0);
    // R5 bit15 by mode, R2 MSB first pattern
    tx_mode_i = 1; tx_rdy_i = 1; fifo_thr_i = 0; live_i = 7'h55; offset_i = 4'hA;
    do_read("R5 tx mode bit15 R2", 16'h8000, 16, 0);
    tx_mode_i = 0; tx_rdy_i = 1; fifo_thr_i = 0;
    do_read("R5 rx mode bit15", 16'h8000, 16, 0);
    // R6 mode-selected source
    tx_mode_i = 0; pulse(0, 1, 0, 0);
    do_read("R6 unf ignored in rx", 16'h8000, 16, 0);
    pulse(0, 0, 1, 0);
    do_read("R6 ovf in rx", 16'h0000, 16, 0);
    tx_mode_i = 1; pulse(0, 0, 1, 0); pulse(0, 1, 0, 0);
    do_read("R6 unf in tx", 16'h0000, 16, 0);
    // R8 falling edge only
    ext_fall();
    do_read("R8 fall sets", 16'h0000, 16, 0);
    @(negedge clk_i); ext_int_ni = 0; repeat (4) @(negedge clk_i); m_sticky[0] = 1;
    do_read("R8 fall then read", 16'h0000, 16, 0);
    do_read("R8 steady low no set", 16'h0000, 16, 0);
    ext_int_ni = 1; repeat (5) @(negedge clk_i);
    do_read("R8 rising no set", 16'h0000, 16, 0);
    // R11 short frame, R10 pending event, R9 sampled at capture
    pulse(1, 0, 0, 0);
    do_read("R11 short frame", 16'h0000, 9, 0);
    do_read("R11 flags survive short", 16'h8000, 16, 0);
    do_read("R10 inject during read", 16'h0000, 16, 1);
    do_read("R10 pending wut kept", 16'h0000, 16, 0);
    do_read("R9 word after perturb", 16'h8000, 16, 0);
    // randomized mix
    for (int k = 0; k < 60; k++) begin
      @(negedge clk_i);
      tx_mode_i = 1'($urandom); tx_rdy_i = 1'($urandom); fifo_thr_i = 1'($urandom);
      live_i = 7'($urandom); offset_i = 4'($urandom);
      pulse(($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 4) == 0);
      if (($urandom % 4) == 0) ext_fall();
      do_read("R3 R4 R9 random", 16'($urandom), (($urandom % 5) == 0) ? 12 : 16,
              ($urandom % 5) == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule